// File: doc/BRIEF.md
# Serial Register Scan-Out Unit

This unit lets software read back any twelve-bit configuration register or any of the three timing counters of a video sync generator one bit at a time. The bits come out on a single output pin, and that pin doubles as the odd/even field flag. Scan mode starts when an address in the scan window is loaded. The address is the register's data address plus 32, and addresses 51 to 53 select the two horizontal counters and the vertical counter. While the unit is in scan mode, its timing-enable output is low. That output gates the timing engine, so every counter and output of the engine stays frozen.

When the load strobe is high, the selected value is captured in parallel into a shift register. It is then shifted out least significant bit first, one bit per clock. After the twelfth bit, the pin keeps showing the most significant bit. Loading any address outside the scan window ends scan mode. The timing engine then continues from the exact point where it stopped. Address decode outside the scan window, and the registers and counters themselves, are supplied by the surrounding logic.

Top module: `scan_shift_unit`

## Requirements
- R1: After reset, `timingEn` is 1 and `serialOut` equals `oddEvenIn`.
- R2: Scan address 32+k (k = 0..18) selects configuration register k, taken from bits [12k+11:12k] of `cfgRegs`. Addresses 51, 52 and 53 select counter 0, 1 and 2, taken from bits [12j+11:12j] of `ctrVals`.
- R3: On the clock after a scan address (32..53) is loaded with `addrValid`, `timingEn` is 0. It stays 0 until a non-scan address is loaded.
- R4: The selected value is captured on the first clock edge after the address load at which `loadHigh` is 1. The capture takes the source value present at that edge. Until then, `serialOut` is 0.
- R5: After capture, `serialOut` shows bit 0 of the captured value. Each further clock advances it by one bit toward bit 11.
- R6: Once bit 11 has been shown, every further clock keeps bit 11 on `serialOut`.
- R7: A change to the source register after capture does not change the scanned bits. Loading the scan address again captures the new value and restarts from bit 0.
- R8: Loading any address outside 32..53 ends scan mode. On the next clock, `timingEn` is 1 and `serialOut` follows `oddEvenIn`.
- R9: While `timingEn` is 1, `serialOut` equals `oddEvenIn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| addrValid | input | 1 | One-cycle strobe: `addrIn` holds a newly loaded address |
| addrIn | input | 6 | Address being loaded |
| loadHigh | input | 1 | Level of the load strobe, synchronised to `clk` |
| cfgRegs | input | 228 | Nineteen 12-bit configuration registers, register k at [12k+11:12k] |
| ctrVals | input | 36 | Three 12-bit counter values, counter j at [12j+11:12j] |
| oddEvenIn | input | 1 | Field flag from the timing generator |
| timingEn | output | 1 | Clock enable for the timing engine; low while scanning |
| serialOut | output | 1 | Shared pin: field flag, or serial scan data |

## Verification
The main function is exercised with a table of addresses and values. The table covers the lowest and highest register addresses, a mid-range register and all three counter addresses. The patterns are chosen so that a swapped bit order, a missing bit or a wrong source index each gives a different bit stream: a single low bit, a single high bit, all ones, and mixed words. Extra clocks after the twelfth bit separate a correct most-significant-bit hold from a zero fill or a wrap-around. Directed cases cover the following:
- holding `loadHigh` low while the source changes, to check when the capture happens;
- changing the source after capture, then reloading the same address;
- jumping from one scan address straight to another;
- the window edges 31 and 54, which must not freeze the timing engine.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic scanOn;    // scan mode active (timing frozen)
    logic waitLoad;  // scan address held, waiting for load high
    logic capture;   // parallel-load the selected source this edge
    logic shift;     // advance the shift register this edge
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32,
  parameter int NUM_SRC   = 22,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              loadHigh,
  output scanStrobe_t       strb,
  output logic [IDX_W-1:0]  selIdx
);
  localparam logic [ADDR_W:0] LO_ADDR = (ADDR_W+1)'(SCAN_BASE);
  localparam logic [ADDR_W:0] HI_ADDR = (ADDR_W+1)'(SCAN_BASE + NUM_SRC);

  logic scanOnQ;
  logic waitLoadQ;
  logic isScan;

  always_comb begin
    isScan = ({1'b0, addrIn} >= LO_ADDR) && ({1'b0, addrIn} < HI_ADDR);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      scanOnQ   <= 1'b0;
      waitLoadQ <= 1'b0;
      selIdx    <= '0;
    end else if (addrValid) begin
      scanOnQ   <= isScan;
      waitLoadQ <= isScan;
      if (isScan) selIdx <= IDX_W'(addrIn - ADDR_W'(SCAN_BASE));
    end else if (waitLoadQ && loadHigh) begin
      waitLoadQ <= 1'b0;
    end
  end

  always_comb begin
    strb.scanOn   = scanOnQ;
    strb.waitLoad = waitLoadQ;
    strb.capture  = scanOnQ && waitLoadQ && loadHigh && !addrValid;
    strb.shift    = scanOnQ && !waitLoadQ && !addrValid;
  end
endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int NUM_CFG = 19,
  parameter int NUM_CTR = 3,
  parameter int IDX_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CFG*DATA_W-1:0]   cfgRegs,
  input  logic [NUM_CTR*DATA_W-1:0]   ctrVals,
  input  logic                        oddEvenIn,
  input  scanStrobe_t                 strb,
  input  logic [IDX_W-1:0]            selIdx,
  output logic                        serialOut
);
  localparam int NUM_SRC  = NUM_CFG + NUM_CTR;
  localparam int NUM_SLOT = 2 ** IDX_W;

  logic [DATA_W-1:0] srcArr [NUM_SLOT];
  logic [DATA_W-1:0] shiftReg;

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_src
    if (g < NUM_CFG) begin : g_cfg
      assign srcArr[g] = cfgRegs[g*DATA_W +: DATA_W];
    end else if (g < NUM_SRC) begin : g_ctr
      assign srcArr[g] = ctrVals[(g-NUM_CFG)*DATA_W +: DATA_W];
    end else begin : g_none
      assign srcArr[g] = '0;
    end
  end

  // Right shift with sign fill: after the last bit, the MSB repeats.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.capture) begin
      shiftReg <= srcArr[selIdx];
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[DATA_W-1], shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    if (!strb.scanOn)       serialOut = oddEvenIn;
    else if (strb.waitLoad) serialOut = 1'b0;
    else                    serialOut = shiftReg[0];
  end
endmodule

// File: rtl/scan_shift_unit.sv
module scan_shift_unit
  import scan_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int NUM_CFG   = 19,
  parameter int NUM_CTR   = 3,
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        addrValid,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic                        loadHigh,
  input  logic [NUM_CFG*DATA_W-1:0]   cfgRegs,
  input  logic [NUM_CTR*DATA_W-1:0]   ctrVals,
  input  logic                        oddEvenIn,
  output logic                        timingEn,
  output logic                        serialOut
);
  localparam int NUM_SRC = NUM_CFG + NUM_CTR;
  localparam int IDX_W   = $clog2(NUM_SRC);

  scanStrobe_t      strb;
  logic [IDX_W-1:0] selIdx;

  scan_ctrl #(
    .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .addrValid(addrValid), .addrIn(addrIn),
    .loadHigh(loadHigh), .strb(strb), .selIdx(selIdx)
  );

  scan_dp #(
    .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .NUM_CTR(NUM_CTR), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rst(rst), .cfgRegs(cfgRegs), .ctrVals(ctrVals),
    .oddEvenIn(oddEvenIn), .strb(strb), .selIdx(selIdx), .serialOut(serialOut)
  );

  assign timingEn = !strb.scanOn;
endmodule

// File: rtl/scan_shift_checker.sv
module scan_shift_checker
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SCAN_BASE = 32,
  parameter int NUM_SRC   = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrIn,
  input logic              oddEvenIn,
  input logic              timingEn,
  input logic              serialOut,
  input scanStrobe_t       strb
);
  logic       inWindow;
  logic [3:0] shiftCnt;

  assign inWindow = (int'(addrIn) >= SCAN_BASE) && (int'(addrIn) < SCAN_BASE + NUM_SRC);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shiftCnt <= '0;
    else if (strb.capture) shiftCnt <= '0;
    else if (strb.shift && shiftCnt != 4'hF) shiftCnt <= shiftCnt + 4'd1;
  end

  a_r3_freeze_on_scan: assert property (@(posedge clk) disable iff (rst)
    (addrValid && inWindow) |=> !timingEn);

  a_r8_resume_on_exit: assert property (@(posedge clk) disable iff (rst)
    (addrValid && !inWindow) |=> timingEn);

  a_r9_field_passthru: assert property (@(posedge clk) disable iff (rst)
    timingEn |-> (serialOut == oddEvenIn));

  a_r4_quiet_before_capture: assert property (@(posedge clk) disable iff (rst)
    strb.waitLoad |-> !serialOut);

  a_r6_msb_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && shiftCnt >= 4'd11) |=> $stable(serialOut));
endmodule

bind scan_shift_unit scan_shift_checker #(
  .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE), .NUM_SRC(NUM_CFG + NUM_CTR)
) chk_i (
  .clk(clk), .rst(rst), .addrValid(addrValid), .addrIn(addrIn),
  .oddEvenIn(oddEvenIn), .timingEn(timingEn), .serialOut(serialOut), .strb(strb)
);

// File: tb/scan_shift_unit_tb.sv
module scan_shift_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addrValid = 1'b0;
  logic [5:0] addrIn = '0;
  logic loadHigh = 1'b1;
  logic [19*12-1:0] cfgRegs = '0;
  logic [3*12-1:0] ctrVals = '0;
  logic oddEvenIn = 1'b0;
  logic timingEn, serialOut;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  scan_shift_unit dut_i (
    .clk(clk), .rst(rst), .addrValid(addrValid), .addrIn(addrIn),
    .loadHigh(loadHigh), .cfgRegs(cfgRegs), .ctrVals(ctrVals),
    .oddEvenIn(oddEvenIn), .timingEn(timingEn), .serialOut(serialOut)
  );

  // {address, value}
  localparam logic [17:0] VEC [0:6] = '{
    {6'd32, 12'hA5C}, {6'd33, 12'h001}, {6'd40, 12'h800}, {6'd50, 12'hFFF},
    {6'd51, 12'h3C7}, {6'd52, 12'h6E1}, {6'd53, 12'hB2D}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic setSrc(input int addr, input logic [11:0] v);
    int idx = addr - 32;
    if (idx < 19) cfgRegs[idx*12 +: 12] = v;
    else ctrVals[(idx-19)*12 +: 12] = v;
  endtask

  task automatic loadAddr(input logic [5:0] a);
    addrValid = 1'b1; addrIn = a;
    tick();
    addrValid = 1'b0;
  endtask

  // After loadAddr with loadHigh=1: one edge to capture, then bits.
  task automatic scanAll(input string tag, input logic [11:0] v, input int extra);
    chk({tag, " frozen"}, timingEn, 1'b0);
    tick();
    for (int k = 0; k < 12 + extra; k++) begin
      chk($sformatf("%s bit%0d", tag, k), serialOut, (k < 12) ? v[k] : v[11]);
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 / R9 reset state and pass-through
    chk("R1 timingEn after reset", timingEn, 1'b1);
    chk("R1 serialOut follows field", serialOut, 1'b0);
    oddEvenIn = 1'b1; #1;
    chk("R9 serialOut follows field", serialOut, 1'b1);

    // R2 R5 R6 table walk
    for (int i = 0; i < 7; i++) begin
      setSrc(int'(VEC[i][17:12]), VEC[i][11:0]);
      loadAddr(VEC[i][17:12]);
      scanAll($sformatf("R2/R5/R6 addr%0d", VEC[i][17:12]), VEC[i][11:0], 3);
    end

    // R7 source change after capture does not alter output; reload rescans
    setSrc(32, 12'h00E);
    loadAddr(6'd32);
    scanAll("R7 first", 12'h00E, 2);
    setSrc(32, 12'hFF1);
    tick();
    chk("R7 held after source change", serialOut, 1'b0);
    loadAddr(6'd32);
    scanAll("R7 rescan", 12'hFF1, 1);

    // R4 capture waits for loadHigh; takes value at that edge
    setSrc(35, 12'h111);
    loadHigh = 1'b0;
    loadAddr(6'd35);
    for (int k = 0; k < 3; k++) begin
      chk("R4 quiet while load low", serialOut, 1'b0);
      chk("R3 frozen while waiting", timingEn, 1'b0);
      tick();
    end
    setSrc(35, 12'h5A6);
    loadHigh = 1'b1;
    tick();
    chk("R4 captured bit0", serialOut, 1'b0);
    tick();
    chk("R4 captured bit1", serialOut, 1'b1);
    tick();
    chk("R4 captured bit2", serialOut, 1'b1);

    // R2 jump to another scan address mid-scan
    setSrc(53, 12'h7FE);
    loadAddr(6'd53);
    scanAll("R2 switch to counter", 12'h7FE, 1);

    // R8 exit with non-scan addresses
    oddEvenIn = 1'b0;
    loadAddr(6'd5);
    chk("R8 timingEn after exit", timingEn, 1'b1);
    chk("R8 field restored", serialOut, 1'b0);
    oddEvenIn = 1'b1; #1;
    chk("R8 field restored high", serialOut, 1'b1);

    // R3 window edges: 31 and 54 never freeze
    loadAddr(6'd31);
    chk("R3 addr31 no freeze", timingEn, 1'b1);
    loadAddr(6'd54);
    chk("R3 addr54 no freeze", timingEn, 1'b1);
    loadAddr(6'd50);
    chk("R3 addr50 freezes", timingEn, 1'b0);
    loadAddr(6'd54);
    chk("R8 addr54 exits scan", timingEn, 1'b1);
    chk("R9 field after addr54", serialOut, oddEvenIn);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule